// File: doc/BRIEF.md
# Framed I/Q sample port

This block carries 12-bit I/Q sample pairs between a transceiver datapath and a baseband processor over two parallel word ports. On the receive side it takes samples from the datapath, drives them onto the port and raises a frame marker. On the transmit side it recovers samples from bursts that an incoming frame marker qualifies. The forwarded data clock and the returned feedback clock are modelled as one domain: every cycle of `clk` is one half of a data-clock period. The block outputs a data clock `dclk` that is high in even cycles and low in odd cycles, counted from reset release.

Four runtime options select the format. Double data rate moves one word per cycle; single data rate moves one word per data-clock period. Dual-port operation carries I and Q side by side; single-port operation sends them one after the other on one port. Pulse framing toggles the marker; level framing holds it. Full duplex splits the bus so that port 0 sends and port 1 receives. In half duplex both ports are shared and the block arbitrates between the two directions. A new option setting takes effect only while the port is idle.

Top module: `iq_frame_port`

## Requirements
- R1: After reset, `p0_oe`, `p1_oe`, `rx_frame`, `tx_valid` and `tx_trunc` are low, and the active format is single-port, single data rate, level framing, half duplex.
- R2: Cycle n after reset release has phase n mod 4, and `dclk` is high exactly in even cycles. The slot length P in cycles is 4 for single-port SDR, 2 for single-port DDR, 2 for dual-port SDR and 1 for dual-port DDR. `rx_ready` is high only in the last cycle of a slot, and a sample accepted there is driven during the whole of the next slot.
- R3: In single-port modes, port 0 carries I in the first half of the slot and Q in the second half. Under SDR each word lasts two cycles and starts on an even cycle. Under DDR each word lasts one cycle.
- R4: In dual-port modes, port 0 carries I and port 1 carries Q for the whole slot, with `p1_oe` high alongside `p0_oe`.
- R5: In level framing, `rx_frame` is high in exactly the cycles in which the port is driven with receive data.
- R6: In pulse framing, a stream is split into units: one slot in single-port modes and two cycles in dual-port modes. `rx_frame` is high in the stream's first unit and inverts at every unit boundary that the stream crosses. A new stream starts high again.
- R7: `tx_frame` is sampled only in even cycles. A burst starts at a unit start whose sample is high when the previous even-cycle sample was low. Words are captured in the slot layout of R3/R4: in every cycle under DDR, in even cycles only under SDR. Each complete pair appears on `tx_i`/`tx_q` with a one-cycle `tx_valid` in the cycle after its last word.
- R8: In level framing, a low `tx_frame` in any even cycle ends the burst, and the word on the port in that cycle is not captured.
- R9: In pulse framing, `tx_frame` must invert at each unit start during a burst. At the first unit start where it has not inverted, the burst ends.
- R10: If a burst ends after the I word of a single-port pair but before its Q word, the pair is dropped, no `tx_valid` is raised for it, and `tx_trunc` is high for one cycle.
- R11: In full duplex, receive data uses port 0 alone in the single-port layout and transmit data is taken from `p1_i`. Both directions run at the same time, `p1_oe` stays low, and the dual-port option is ignored.
- R12: In half duplex, `rx_ready` is low and the port is undriven while a burst is active. A burst start wins over a receive sample offered in the same cycle. A `tx_frame` rise while receive data is driving the port is ignored.
- R13: Option changes are held while a receive stream or a transmit burst is active, and take effect once both are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one cycle per data-clock half |
| rst_n | input | 1 | Active-low reset |
| cfg_ddr | input | 1 | Requested double data rate |
| cfg_dual | input | 1 | Requested dual-port layout |
| cfg_pulse | input | 1 | Requested pulse framing |
| cfg_fdx | input | 1 | Requested full duplex |
| rx_valid | input | 1 | Datapath offers a receive sample |
| rx_i | input | W | Receive I word |
| rx_q | input | W | Receive Q word |
| rx_ready | output | 1 | Sample taken at this edge when `rx_valid` |
| dclk | output | 1 | Forwarded data clock |
| rx_frame | output | 1 | Receive frame marker |
| p0_o | output | W | Port 0 outgoing word |
| p0_oe | output | 1 | Port 0 drive enable |
| p1_o | output | W | Port 1 outgoing word |
| p1_oe | output | 1 | Port 1 drive enable |
| p0_i | input | W | Port 0 incoming word |
| p1_i | input | W | Port 1 incoming word |
| tx_frame | input | 1 | Incoming transmit frame marker |
| tx_valid | output | 1 | Recovered pair is valid |
| tx_i | output | W | Recovered I word |
| tx_q | output | W | Recovered Q word |
| tx_trunc | output | 1 | Partial pair dropped at burst end |

## Verification
In half duplex, a receive sample offer and a transmit burst start can fall in one cycle. In dual-port DDR every cycle closes a slot, so this happens when `rx_valid` and a `tx_frame` rise are presented in the same even cycle. The bench expects `rx_ready` to be low in that cycle, the burst pairs to arrive intact, and the held receive sample to appear on the port only after the burst ends. The opposite case is also driven: a frame rise during an active receive stream must yield no transmit pair, and the receive words must continue undisturbed.

// File: rtl/iq_frame_port.sv
module iq_frame_port #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_ddr,
  input  logic         cfg_dual,
  input  logic         cfg_pulse,
  input  logic         cfg_fdx,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] rx_q,
  output logic         rx_ready,
  output logic         dclk,
  output logic         rx_frame,
  output logic [W-1:0] p0_o,
  output logic         p0_oe,
  output logic [W-1:0] p1_o,
  output logic         p1_oe,
  input  logic [W-1:0] p0_i,
  input  logic [W-1:0] p1_i,
  input  logic         tx_frame,
  output logic         tx_valid,
  output logic [W-1:0] tx_i,
  output logic [W-1:0] tx_q,
  output logic         tx_trunc
);

  logic [1:0]   ph;
  logic         m_ddr, m_dual, m_pulse, m_fdx;
  logic         rx_act, par;
  logic [W-1:0] hi, hq;
  logic         tx_act, fr_q, got_i;
  logic [W-1:0] ti;

  logic       dual_e, rising, beat, cap;
  logic [1:0] pm, um;
  logic       slot_end, unit_end, unit_start;
  logic       tx_go, end_now, live, rx_go, idle;
  logic [W-1:0] tpa;

  assign dual_e     = m_dual & ~m_fdx;
  assign pm         = dual_e ? (m_ddr ? 2'd0 : 2'd1) : (m_ddr ? 2'd1 : 2'd3);
  assign um         = dual_e ? 2'd1 : pm;
  assign slot_end   = (ph & pm) == pm;
  assign unit_end   = (ph & um) == um;
  assign unit_start = (ph & um) == 2'd0;
  assign rising     = ~ph[0];
  assign beat       = dual_e ? 1'b0 : (m_ddr ? ph[0] : ph[1]);
  assign cap        = m_ddr | rising;
  assign tpa        = m_fdx ? p1_i : p0_i;

  assign tx_go    = ~tx_act & unit_start & tx_frame & ~fr_q & (m_fdx | ~rx_act);
  assign end_now  = tx_act & (m_pulse ? (unit_start & (tx_frame == fr_q))
                                      : (rising & ~tx_frame));
  assign live     = (tx_act | tx_go) & ~end_now;
  assign rx_ready = slot_end & (m_fdx | (~tx_act & ~tx_go));
  assign rx_go    = rx_valid & rx_ready;
  assign idle     = ~rx_act & ~tx_act & ~tx_go & ~rx_go;

  assign dclk     = ~ph[0];
  assign p0_oe    = rx_act;
  assign p0_o     = rx_act ? ((dual_e | ~beat) ? hi : hq) : '0;
  assign p1_oe    = rx_act & dual_e;
  assign p1_o     = p1_oe ? hq : '0;
  assign rx_frame = rx_act & (~m_pulse | ~par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      m_ddr   <= 1'b0;
      m_dual  <= 1'b0;
      m_pulse <= 1'b0;
      m_fdx   <= 1'b0;
    end else begin
      ph <= ph + 2'd1;
      if (idle) begin
        m_ddr   <= cfg_ddr;
        m_dual  <= cfg_dual;
        m_pulse <= cfg_pulse;
        m_fdx   <= cfg_fdx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0;
      par    <= 1'b0;
      hi     <= '0;
      hq     <= '0;
    end else if (slot_end) begin
      rx_act <= rx_go;
      if (rx_go) begin
        hi <= rx_i;
        hq <= rx_q;
        if (!rx_act)       par <= 1'b0;
        else if (unit_end) par <= ~par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act   <= 1'b0;
      fr_q     <= 1'b0;
      got_i    <= 1'b0;
      ti       <= '0;
      tx_i     <= '0;
      tx_q     <= '0;
      tx_valid <= 1'b0;
      tx_trunc <= 1'b0;
    end else begin
      if (rising) fr_q <= tx_frame;
      tx_act   <= (tx_act & ~end_now) | tx_go;
      tx_valid <= 1'b0;
      tx_trunc <= end_now & got_i;
      if (end_now) got_i <= 1'b0;
      if (live && cap) begin
        if (dual_e) begin
          tx_i     <= p0_i;
          tx_q     <= p1_i;
          tx_valid <= 1'b1;
        end else if (!beat) begin
          ti    <= tpa;
          got_i <= 1'b1;
        end else begin
          tx_i     <= ti;
          tx_q     <= tpa;
          tx_valid <= 1'b1;
          got_i    <= 1'b0;
        end
      end
    end
  end

endmodule

module iq_frame_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_act,
  input logic       tx_act,
  input logic       m_fdx,
  input logic [3:0] mode,
  input logic       p0_oe,
  input logic       p1_oe,
  input logic       rx_ready,
  input logic       rx_frame,
  input logic       tx_valid,
  input logic       tx_trunc
);

  // R12
  hdx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && !m_fdx) |-> (!p0_oe && !rx_ready));

  // R13
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_act || tx_act) |=> $stable(mode));

  // R10
  trunc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trunc |-> !tx_valid);

  // R10
  trunc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trunc |-> $past(tx_act));

  // R11
  p1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p1_oe |-> (p0_oe && !m_fdx));

  // R5
  frame_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame |-> p0_oe);

endmodule

bind iq_frame_port iq_frame_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .tx_act(tx_act), .m_fdx(m_fdx),
  .mode({m_ddr, m_dual, m_pulse, m_fdx}), .p0_oe(p0_oe), .p1_oe(p1_oe),
  .rx_ready(rx_ready), .rx_frame(rx_frame), .tx_valid(tx_valid),
  .tx_trunc(tx_trunc)
);

// File: tb/tb_iq_frame_port.sv
module tb_iq_frame_port;
  localparam int  W    = 12;
  localparam time TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ddr = 0, cfg_dual = 0, cfg_pulse = 0, cfg_fdx = 0;
  logic rx_valid = 0, tx_frame = 0;
  logic [W-1:0] rx_i = '0, rx_q = '0, p0_i = '0, p1_i = '0;
  logic rx_ready, dclk, rx_frame, p0_oe, p1_oe, tx_valid, tx_trunc;
  logic [W-1:0] p0_o, p1_o, tx_i, tx_q;

  iq_frame_port #(.W(W)) dut (.*);

  always #(TCLK/2) clk = ~clk;

  int cnt = 0, n_run = 0, n_fail = 0, n_trunc = 0, n_tv = 0;
  bit b_ddr = 0, b_dual = 0, b_pulse = 0, b_fdx = 0;
  logic [2*W-1:0] rxq[$], txq[$];
  logic [W-1:0] cur_i;
  bit prev_oe = 0, epar = 0;

  always @(posedge clk) if (rst_n) cnt <= cnt + 1;

  function automatic bit de(); return b_dual && !b_fdx; endfunction
  function automatic int pl(); return de() ? (b_ddr ? 1 : 2) : (b_ddr ? 2 : 4); endfunction
  function automatic int ul(); return de() ? 2 : pl(); endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic rx_done(logic [W-1:0] i, logic [W-1:0] q);
    logic [2*W-1:0] e;
    if (rxq.size() == 0) begin
      chk(0, "R2 unexpected rx sample", {i, q}, 0);
    end else begin
      e = rxq.pop_front();
      chk({i, q} == e, "R3/R4 rx words", {i, q}, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      int o;
      o = cnt % pl();
      if (p0_oe && o == 0) begin
        if (!prev_oe) epar = 0;
        else if ((cnt - 1) % ul() == ul() - 1) epar = ~epar;
        chk(rx_frame == (b_pulse ? !epar : 1'b1), b_pulse ? "R6 rx frame" : "R5 rx frame",
            rx_frame, b_pulse ? !epar : 1'b1);
        if (de()) begin
          chk(p1_oe == 1'b1, "R4 p1 drive", p1_oe, 1);
          rx_done(p0_o, p1_o);
        end else cur_i = p0_o;
      end
      if (p0_oe && !de() && o == pl() / 2) rx_done(cur_i, p0_o);
      if (!p0_oe && rx_frame) chk(0, "R5 frame without data", 1, 0);
      if (b_fdx && p1_oe) chk(0, "R11 p1 driven in full duplex", 1, 0);
      prev_oe = p0_oe;
      if (tx_trunc) n_trunc++;
      if (tx_valid) begin
        n_tv++;
        if (txq.size() == 0) chk(0, "R12 unexpected tx pair", {tx_i, tx_q}, 0);
        else begin
          logic [2*W-1:0] e;
          e = txq.pop_front();
          chk({tx_i, tx_q} == e, "R7 tx pair", {tx_i, tx_q}, e);
        end
      end
    end
  end

  task automatic set_mode(bit d, bit du, bit pu, bit fd);
    cfg_ddr = d; cfg_dual = du; cfg_pulse = pu; cfg_fdx = fd;
    repeat (4) @(negedge clk);
    b_ddr = d; b_dual = du; b_pulse = pu; b_fdx = fd;
  endtask

  task automatic rx_send(int n, int base);
    for (int k = 0; k < n; k++) begin
      rx_i = W'(base + 2 * k);
      rx_q = W'(base + 2 * k + 1);
      rx_valid = 1'b1;
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      rxq.push_back({rx_i, rx_q});
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic tx_send(int n, int base, bit partial);
    int p, u;
    bit stop;
    p = pl(); u = ul(); stop = 0;
    while (cnt % u != 0) @(negedge clk);
    for (int k = 0; k < n && !stop; k++) begin
      logic [W-1:0] iw, qw;
      iw = W'(base + 2 * k);
      qw = W'(base + 2 * k + 1);
      if (!(partial && k == n - 1)) txq.push_back({iw, qw});
      for (int o = 0; o < p && !stop; o++) begin
        stop = partial && k == n - 1 && !de() && o >= p / 2;
        tx_frame = stop ? 1'b0 : (b_pulse ? (((k * p + o) / u) % 2 == 0) : 1'b1);
        if (de()) begin p0_i = iw; p1_i = qw; end
        else if (b_fdx) p1_i = (o < p / 2) ? iw : qw;
        else p0_i = (o < p / 2) ? iw : qw;
        @(negedge clk);
      end
    end
    if (!partial && b_pulse) repeat (u) @(negedge clk);
    tx_frame = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(TCLK * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({p0_oe, p1_oe, rx_frame, tx_valid, tx_trunc} == 5'b0, "R1 idle outputs",
        {p0_oe, p1_oe, rx_frame, tx_valid, tx_trunc}, 0);
    // R2 dclk and ready phase in default single-port SDR
    for (int c = 0; c < 8; c++) begin
      chk(dclk == (cnt % 2 == 0), "R2 dclk", dclk, cnt % 2 == 0);
      chk(rx_ready == (cnt % 4 == 3), "R2 ready slot", rx_ready, cnt % 4 == 3);
      @(negedge clk);
    end
    // R1 default format is single SDR level: observed by the monitor
    rx_send(3, 'h100); repeat (6) @(negedge clk);

    set_mode(1, 0, 1, 0); rx_send(4, 'h200); repeat (6) @(negedge clk);  // R3 R6
    set_mode(0, 1, 0, 0); rx_send(3, 'h300); repeat (6) @(negedge clk);  // R4 R5
    set_mode(1, 1, 1, 0); rx_send(5, 'h400); repeat (6) @(negedge clk);  // R4 R6

    // R7 R8 R9 transmit bursts
    set_mode(0, 0, 0, 0); tx_send(3, 'h500, 0);
    set_mode(1, 0, 1, 0); tx_send(4, 'h600, 0);
    set_mode(0, 1, 0, 0); tx_send(2, 'h700, 0);
    set_mode(1, 1, 1, 0); tx_send(4, 'h800, 0);
    chk(txq.size() == 0, "R9 all bursts delivered", txq.size(), 0);

    // R10 partial pair
    set_mode(0, 0, 0, 0);
    n_trunc = 0;
    tx_send(2, 'h900, 1);
    chk(n_trunc == 1, "R10 trunc pulses", n_trunc, 1);
    chk(txq.size() == 0, "R10 partial not delivered", txq.size(), 0);

    // R11 full duplex, dual option ignored
    set_mode(1, 1, 0, 1);
    fork
      rx_send(4, 'hA00);
      tx_send(3, 'hB00, 0);
    join
    repeat (6) @(negedge clk);
    chk(rxq.size() == 0 && txq.size() == 0, "R11 both directions", rxq.size() + txq.size(), 0);

    // R12 same-cycle contention: burst start wins
    set_mode(1, 1, 0, 0);
    while (cnt % 2 != 0) @(negedge clk);
    fork
      tx_send(2, 'hC00, 0);
      rx_send(2, 'hD00);
      begin #1; chk(rx_ready == 1'b0, "R12 ready low at burst start", rx_ready, 0); end
    join
    repeat (6) @(negedge clk);
    chk(rxq.size() == 0 && txq.size() == 0, "R12 both delivered", rxq.size() + txq.size(), 0);

    // R12 frame rise during receive stream is ignored
    set_mode(1, 0, 0, 0);
    n_tv = 0;
    fork
      rx_send(6, 'hE00);
      begin repeat (3) @(negedge clk); tx_frame = 1'b1; repeat (16) @(negedge clk); tx_frame = 1'b0; end
    join
    repeat (6) @(negedge clk);
    chk(n_tv == 0, "R12 no burst during rx", n_tv, 0);

    // R13 option change held during a stream
    set_mode(0, 0, 0, 0);
    fork
      rx_send(4, 'hF00);
      begin repeat (5) @(negedge clk); cfg_ddr = 1; cfg_dual = 1; end
    join
    repeat (6) @(negedge clk);
    chk(rxq.size() == 0, "R13 old format kept", rxq.size(), 0);
    set_mode(1, 1, 0, 0);
    rx_send(3, 'h050); repeat (6) @(negedge clk);
    chk(rxq.size() == 0, "R13 new format applied", rxq.size(), 0);

    finish_run();
  end
endmodule